// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides an already pre-divided oscillator clock by a programmable ratio N = 32*M + S. Inside, a dual-modulus prescaler counts either 32 or 33 clock cycles per prescaler cycle. A main counter sets how many prescaler cycles make up one output period. A swallow counter sets how many of those prescaler cycles use the longer modulus. At the end of each period the block emits a single-cycle pulse. That pulse feeds a phase comparator and a test output selector.

A register block writes new M and S values with a one-cycle load strobe. Each load goes into a staging register. The counters pick up the staged values only when the current period ends. A period therefore always runs to completion with the ratio it started with.

Top module: `swallow_div`

## Requirements
- R1: The pulse on `div_pulse` repeats every N = 32*M + S clock cycles, where M is the staged main value (32..1023) and S is the staged swallow value (0..31).
- R2: In each period the prescaler runs the first S prescaler cycles at modulus 33 and the remaining M - S prescaler cycles at modulus 32.
- R3: When S = 0, every prescaler cycle in the period uses modulus 32, giving N = 32*M.
- R4: A loaded M below 32 is stored as 32, so the period becomes 1024 + S.
- R5: `div_pulse` is high for exactly one clock cycle, which is the last cycle of each period. After the pulse, the prescaler count starts again from zero.
- R6: A load takes effect at the first period boundary after it. The running period keeps its old ratio. A load in the same cycle as a pulse applies one period later.
- R7: While reset is asserted, `div_pulse` is low. After `rst_n` rises, the synchronizer needs two clock edges. The cycle that follows is cycle 0 of a period with M = 32 and S = 0, so the first pulse comes in cycle 1023.
- R8: If several loads arrive within one period, only the last one sets the next period's ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pre-divided oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | One-cycle strobe that stages `m_in` and `s_in` |
| m_in | input | 10 | Main counter value |
| s_in | input | 5 | Swallow counter value |
| div_pulse | output | 1 | One-cycle pulse at the end of each period |

## Verification
A corrupted counter or staged value shows at the output as a wrong pulse spacing. A wrong prescaler modulus shifts the pulse by up to S cycles. A wrong main count shifts it by multiples of 32 cycles. In both cases the error appears no later than the first pulse after the fault. The pulse position is compared in every cycle, so a single-cycle slip is reported in the cycle where it happens. A staging error is visible in the period right after the load that should have applied.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  parameter int unsigned MAIN_W = 10;
  parameter int unsigned SWAL_W = 5;
  parameter int unsigned BASE_MOD = 32;
  parameter int unsigned MAIN_MIN = 32;
  localparam int unsigned PRE_W = $clog2(BASE_MOD + 1);
endpackage

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
  parameter int unsigned BASE  = 32,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_hi,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(BASE - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(BASE);

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    wrap    = (cnt == (mod_hi ? LAST_HI : LAST_LO));
    cnt_nxt = wrap ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/swdiv_swallow.sv
module swdiv_swallow #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload,
  input  logic [W-1:0] s_load,
  input  logic         step,
  output logic         mod_hi
);
  logic [W-1:0] left_q, left_nxt;
  logic         en;

  always_comb begin
    mod_hi   = (left_q != '0);
    en       = reload | (step & mod_hi);
    left_nxt = reload ? s_load : left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  left_q <= '0;
    else if (en) left_q <= left_nxt;
  end
endmodule

// File: rtl/swdiv_main.sv
module swdiv_main #(
  parameter int unsigned W     = 10,
  parameter int unsigned RST_M = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload,
  input  logic [W-1:0] m_load,
  input  logic         step,
  output logic         last
);
  logic [W-1:0] left_q, left_nxt;
  logic         en;

  always_comb begin
    last     = step & (left_q == W'(1));
    en       = reload | step;
    left_nxt = reload ? m_load : left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  left_q <= W'(RST_M);
    else if (en) left_q <= left_nxt;
  end
endmodule

// File: rtl/swallow_div.sv
module swallow_div
  import swdiv_pkg::*;
#(
  parameter int unsigned M_W  = MAIN_W,
  parameter int unsigned S_W  = SWAL_W,
  parameter int unsigned BASE = BASE_MOD,
  parameter int unsigned MMIN = MAIN_MIN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [M_W-1:0] m_in,
  input  logic [S_W-1:0] s_in,
  output logic           div_pulse
);
  localparam int unsigned PW = $clog2(BASE + 1);
  localparam logic [M_W-1:0] M_FLOOR = M_W'(MMIN);

  logic           rs_q1, rst_i;
  logic [M_W-1:0] stage_m, m_fix;
  logic [S_W-1:0] stage_s;
  logic [PW-1:0]  pre_cnt;
  logic           pre_end, mod_hi, period_end;

  // Reset: asserted asynchronously, released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rst_i <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rst_i <= rs_q1;
    end
  end

  always_comb m_fix = (m_in < M_FLOOR) ? M_FLOOR : m_in;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      stage_m <= M_FLOOR;
      stage_s <= '0;
    end else if (load) begin
      stage_m <= m_fix;
      stage_s <= s_in;
    end
  end

  swdiv_prescaler #(.BASE(BASE), .CNT_W(PW)) u_pre (
    .clk(clk), .rst_n(rst_i), .mod_hi(mod_hi), .cnt(pre_cnt), .wrap(pre_end)
  );

  swdiv_swallow #(.W(S_W)) u_swl (
    .clk(clk), .rst_n(rst_i), .reload(period_end), .s_load(stage_s),
    .step(pre_end), .mod_hi(mod_hi)
  );

  swdiv_main #(.W(M_W), .RST_M(MMIN)) u_main (
    .clk(clk), .rst_n(rst_i), .reload(period_end), .m_load(stage_m),
    .step(pre_end), .last(period_end)
  );

  assign div_pulse = period_end;
endmodule

// File: rtl/swallow_div_chk.sv
module swallow_div_chk #(
  parameter int unsigned M_W  = 10,
  parameter int unsigned S_W  = 5,
  parameter int unsigned PW   = 6,
  parameter int unsigned MMIN = 32
) (
  input logic           clk,
  input logic           rst_i,
  input logic           div_pulse,
  input logic           pre_end,
  input logic           mod_hi,
  input logic [PW-1:0]  pre_cnt,
  input logic [M_W-1:0] stage_m,
  input logic [S_W-1:0] stage_s
);
  // R2: a period with nonzero swallow opens at modulus 33
  a_r2_opens_long: assert property (@(posedge clk) disable iff (!rst_i)
    (div_pulse && stage_s != '0) |=> mod_hi);

  // R3: zero swallow keeps modulus 32 from the first cycle
  a_r3_zero_short: assert property (@(posedge clk) disable iff (!rst_i)
    (div_pulse && stage_s == '0) |=> !mod_hi);

  // R4: staged main value never below the floor
  a_r4_floor: assert property (@(posedge clk) disable iff (!rst_i)
    stage_m >= M_W'(MMIN));

  // R5: single-cycle pulse on a prescaler boundary, prescaler restarts
  a_r5_one_wide: assert property (@(posedge clk) disable iff (!rst_i)
    div_pulse |=> !div_pulse);
  a_r5_on_wrap: assert property (@(posedge clk) disable iff (!rst_i)
    div_pulse |-> pre_end);
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_i)
    div_pulse |=> pre_cnt == '0);

  // R7: quiet while held in reset
  always @(posedge clk) begin
    if (!rst_i) a_r7_quiet: assert (!div_pulse);
  end
endmodule

bind swallow_div swallow_div_chk #(.M_W(M_W), .S_W(S_W), .PW(PW), .MMIN(MMIN)) u_chk (
  .clk(clk), .rst_i(rst_i), .div_pulse(div_pulse), .pre_end(pre_end),
  .mod_hi(mod_hi), .pre_cnt(pre_cnt), .stage_m(stage_m), .stage_s(stage_s)
);

// File: tb/swallow_div_test.sv
module swallow_div_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [9:0] m_in = '0;
  logic [4:0] s_in = '0;
  logic       div_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference state
  int  ref_cnt = 0, ref_n = 1024, st_m = 32, st_s = 0;
  int  sync_wait = 0;
  bit  in_reset = 1;

  always #4 clk = ~clk;

  swallow_div uut (
    .clk(clk), .rst_n(rst_n), .load(load), .m_in(m_in), .s_in(s_in),
    .div_pulse(div_pulse)
  );

  function automatic int fix_m(input int m);
    return (m < 32) ? 32 : m;
  endfunction

  function automatic int ratio(input int m, input int s);
    return 32 * fix_m(m) + s;
  endfunction

  task automatic tick(input bit ld, input int m, input int s, input string tag);
    bit exp;
    @(negedge clk);
    cycles++;
    exp = (in_reset || sync_wait > 0) ? 1'b0 : (ref_cnt == ref_n - 1);
    checks++;
    if (div_pulse !== exp) begin
      errors++;
      $display("FAIL %s: div_pulse=%0b expected %0b (period cycle %0d of %0d)",
               tag, div_pulse, exp, ref_cnt, ref_n);
    end
    load = ld; m_in = 10'(m); s_in = 5'(s);
    if (in_reset) begin
    end else if (sync_wait > 0) begin
      sync_wait--;
    end else begin
      if (ref_cnt == ref_n - 1) begin
        ref_cnt = 0;
        ref_n = 32 * st_m + st_s;
      end else ref_cnt++;
      if (ld) begin
        st_m = fix_m(m);
        st_s = s;
      end
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(0, 0, 0, tag);
  endtask

  task automatic load_at_pulse(input int m, input int s, input string tag);
    while (ref_cnt != ref_n - 1) tick(0, 0, 0, tag);
    tick(1, m, s, tag);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int r;
    r = $urandom(2024);
    // R7: reset quiet, then default 1024 period
    for (int i = 0; i < 5; i++) tick(0, 0, 0, "R7");
    rst_n = 1'b1; in_reset = 0; sync_wait = 1;
    ref_cnt = 0; ref_n = 1024; st_m = 32; st_s = 0;
    run(2200, "R7");
    // R2 / R1: mixed moduli
    tick(1, 40, 17, "R2");
    run(3000, "R2");
    // R3: zero swallow
    tick(1, 33, 0, "R3");
    run(2300, "R3");
    // R1: largest swallow with smallest main
    tick(1, 32, 31, "R1");
    run(2300, "R1");
    // R4: clamp of small main values
    tick(1, 5, 3, "R4");
    run(2200, "R4");
    tick(1, 0, 0, "R4");
    run(2200, "R4");
    // R6: load in the pulse cycle and mid-period
    load_at_pulse(50, 9, "R6");
    run(3300, "R6");
    run(400, "R6");
    tick(1, 36, 2, "R6");
    run(2500, "R6");
    // R8: two loads in one period, last wins
    tick(1, 60, 20, "R8");
    run(10, "R8");
    tick(1, 34, 5, "R8");
    run(2300, "R8");
    // R1: largest main value
    tick(1, 1023, 0, "R1");
    run(66000, "R1");
    // R5: random loads
    for (int i = 0; i < 30000; i++) begin
      if ($urandom_range(299) == 0) begin
        int m;
        m = ($urandom_range(3) == 0) ? $urandom_range(31) : $urandom_range(80, 32);
        tick(1, m, $urandom_range(31), "R5");
      end else tick(0, 0, 0, "R5");
    end
    finish_run();
  end

  initial begin
    while (cycles < 190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: cycles=%0d expected fewer than 190000", cycles);
    finish_run();
  end
endmodule